// File: doc/BRIEF.md
# Variable-Length Bitstream Packer

The packer takes a sequence of variable-length codewords and joins them into one continuous bitstream. Each codeword is a right-aligned value with a length of 0 to 32 bits, and it enters the block through a valid/ready handshake. The earliest bit of the stream always sits at the most significant end. Whenever 32 stream bits have gathered, the block writes them as one word to a memory write port. The word goes to an address that starts at a programmed base and steps by one word for each write. The bytes are placed in memory in one of two layouts, and a swap bit picks which one.

A run begins with a start pulse and ends with the codeword flagged as last. A partly filled word is never written at the end of a run. The block keeps it instead and exposes it as an upper half, a lower half and a count of valid bits. Software reads these three values back and supplies them again with the next start, so the following run continues the same stream with no gap.

The block keeps three bit counters. The first codewords of a run, up to a programmed number of header pairs, are added to a header counter. Every later codeword is added to a residual counter. A total counter adds up all accepted lengths plus the bits carried in at the start.

Top module: `vlc_bit_packer`

## Requirements
- R1: After reset, busy, done, wr_en and cw_ready are low, and the pending halves, the pending count and all three counters are zero.
- R2: An accepted codeword adds only the low cw_len bits of cw_code to the stream, and bit cw_len-1 comes first. Bits of cw_code above the length are ignored. A length of 0 adds no bits. Legal lengths are 0 to 32.
- R3: When an accepted codeword brings the number of stream bits to 32 or more, the oldest 32 bits are written once, with wr_en high for one cycle after that clock edge. The remaining bits stay pending.
- R4: With swap at 0, a written word holds stream bits 16-23 in wr_data[31:24], bits 24-31 in [23:16], bits 0-7 in [15:8] and bits 8-15 in [7:0]. Stream bit 0 is the first bit of the word, and within each byte the earlier bit is the more significant one.
- R5: With swap at 1, a written word holds stream bits 24-31 in [31:24], bits 16-23 in [23:16], bits 8-15 in [15:8] and bits 0-7 in [7:0], with the same bit order inside each byte.
- R6: The first word of a run is written to the base address sampled at start. Each later word goes to the previous address plus one.
- R7: pend_hi holds pending stream bits 0-15 (bit 0 at pend_hi[15]) and pend_lo holds bits 16-31. pend_cnt gives the number of valid bits and is always below 32. Every bit after the valid ones reads as zero.
- R8: A start pulse in idle loads the carry-in halves and count as the pending bits and discards any carry-in bits beyond the count. The new codewords then follow those bits directly.
- R9: The first cfg_hdr_pairs accepted codewords of a run (0 to 1023) add their lengths to hdr_bits. All later codewords add to res_bits. Both counters clear at start.
- R10: tot_bits equals the carry-in count loaded at start plus the sum of all lengths accepted in the run.
- R11: After the clock edge that accepts a codeword with cw_last set, done is high for exactly one cycle and busy is low. At that point the pending state and the counters already show the whole run.
- R12: cw_ready is high exactly while a run is active. A start pulse during a run is ignored, and the run's address, layout and counters carry on unchanged.
- R13: The swap bit and the base address are sampled at start and stay fixed for the whole run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| cfg_swap | input | 1 | Byte layout select, sampled at start |
| cfg_base | input | ADDR_W | Word address of the first write, sampled at start |
| cfg_hdr_pairs | input | HDR_W | Number of leading codewords counted as header |
| resume_hi | input | 16 | Carry-in upper half of the pending word |
| resume_lo | input | 16 | Carry-in lower half of the pending word |
| resume_cnt | input | 5 | Number of valid carry-in bits |
| cw_valid | input | 1 | Codeword present |
| cw_ready | output | 1 | Codeword accepted this cycle when valid |
| cw_code | input | 32 | Codeword value, right-aligned |
| cw_len | input | 6 | Codeword length, 0 to 32 |
| cw_last | input | 1 | Marks the final codeword of the run |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory word address |
| wr_data | output | 32 | Memory write data in the selected layout |
| busy | output | 1 | Run active |
| done | output | 1 | One-cycle pulse at the end of a run |
| pend_hi | output | 16 | Pending upper half |
| pend_lo | output | 16 | Pending lower half |
| pend_cnt | output | 5 | Number of pending valid bits |
| tot_bits | output | CNT_W | Carry-in plus all generated bits |
| hdr_bits | output | CNT_W | Bits from header codewords |
| res_bits | output | CNT_W | Bits from residual codewords |

## Verification
Directed lists with a known first codeword give literal memory words for each byte layout. Together with zero-length and full-width codewords, they tell a wrong byte or halfword placement apart from a wrong shift or mask. Long random runs use lengths from 0 to 32 and random garbage above each length. These runs separate correct splitting at word boundaries from off-by-one fill errors, and they show whether the high bits leak into the stream. Chained runs hand the model's own pending bits back in, with garbage below the count and a count of 31. These runs test the seamless continuation and the masking of carry-in bits. Header-pair settings of 0, 2, 5 and 1023, and a start pulse injected mid-run, tell correct category splitting apart from a run that restarts or miscounts.

// File: rtl/vlcpk_pkg.sv
package vlcpk_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int LEN_W  = $clog2(WORD_W) + 1;
    localparam int FILL_W = $clog2(WORD_W);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/vlcpk_merge.sv
// Appends one right-aligned codeword behind the pending bits held MSB-first.
module vlcpk_merge
    import vlcpk_pkg::*;
(
    input  logic [WORD_W-1:0] acc_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic [WORD_W-1:0] code_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [FILL_W-1:0] fill_o
);
    localparam int WIDE_W = 2 * WORD_W;
    localparam int SH_W   = $clog2(WIDE_W) + 1;

    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] code_m;
    logic [SH_W-1:0]   sum;
    logic [SH_W-1:0]   sh;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        if (len_i >= LEN_W'(WORD_W)) begin
            mask = '1;
        end else begin
            mask = ~({WORD_W{1'b1}} << len_i);
        end
        code_m = code_i & mask;
        sum    = SH_W'(fill_i) + SH_W'(len_i);
        sh     = SH_W'(WIDE_W) - sum;
        // pending bits occupy the top of the wide window, the codeword lands right behind them
        wide   = {acc_i, {WORD_W{1'b0}}} | ({{WORD_W{1'b0}}, code_m} << sh);
        full_o = (sum >= SH_W'(WORD_W));
        word_o = wide[WIDE_W-1:WORD_W];
        if (full_o) begin
            acc_o  = wide[WORD_W-1:0];
            fill_o = FILL_W'(sum - SH_W'(WORD_W));
        end else begin
            acc_o  = wide[WIDE_W-1:WORD_W];
            fill_o = FILL_W'(sum);
        end
    end
endmodule

// File: rtl/vlcpk_lane_map.sv
// Places the four stream bytes of a completed word into memory byte lanes.
module vlcpk_lane_map
    import vlcpk_pkg::*;
(
    input  logic              swap_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] mem_o
);
    localparam int BYTES = WORD_W / 8;

    // stream byte s sits at word_i[WORD_W-1-8*s -: 8]; swap=1 puts it in lane s, swap=0 in lane s^1
    for (genvar m = 0; m < BYTES; m++) begin : g_lane
        assign mem_o[8*m +: 8] = swap_i ? word_i[WORD_W-1-8*m -: 8]
                                        : word_i[WORD_W-1-8*(m^1) -: 8];
    end

    always_comb begin
        AST_LANE_PERMUTE: assert ($countones(mem_o) == $countones(word_i)); // R4
    end
endmodule

// File: rtl/vlc_bit_packer.sv
module vlc_bit_packer
    import vlcpk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 24,
    parameter int HDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_swap,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [HDR_W-1:0]  cfg_hdr_pairs,
    input  logic [HALF_W-1:0] resume_hi,
    input  logic [HALF_W-1:0] resume_lo,
    input  logic [FILL_W-1:0] resume_cnt,
    input  logic              cw_valid,
    output logic              cw_ready,
    input  logic [WORD_W-1:0] cw_code,
    input  logic [LEN_W-1:0]  cw_len,
    input  logic              cw_last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [HALF_W-1:0] pend_hi,
    output logic [HALF_W-1:0] pend_lo,
    output logic [FILL_W-1:0] pend_cnt,
    output logic [CNT_W-1:0]  tot_bits,
    output logic [CNT_W-1:0]  hdr_bits,
    output logic [CNT_W-1:0]  res_bits
);
    typedef struct packed {
        run_state_e        state;
        logic              swap;
        logic [ADDR_W-1:0] addr;
        logic [HDR_W-1:0]  hdr_left;
        logic [WORD_W-1:0] acc;
        logic [FILL_W-1:0] fill;
        logic [CNT_W-1:0]  tot;
        logic [CNT_W-1:0]  hdr;
        logic [CNT_W-1:0]  res;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [WORD_W-1:0] wr_word;
        logic              done;
    } pk_state_t;

    pk_state_t st_d, st_q;

    logic              mg_full;
    logic [WORD_W-1:0] mg_word;
    logic [WORD_W-1:0] mg_acc;
    logic [FILL_W-1:0] mg_fill;
    logic              accept;
    logic [WORD_W-1:0] keep_mask;

    vlcpk_merge u_merge (
        .acc_i  (st_q.acc),
        .fill_i (st_q.fill),
        .code_i (cw_code),
        .len_i  (cw_len),
        .full_o (mg_full),
        .word_o (mg_word),
        .acc_o  (mg_acc),
        .fill_o (mg_fill)
    );

    vlcpk_lane_map u_lane (
        .swap_i (st_q.swap),
        .word_i (st_q.wr_word),
        .mem_o  (wr_data)
    );

    assign accept    = (st_q.state == ST_RUN) && cw_valid;
    assign keep_mask = ~({WORD_W{1'b1}} >> resume_cnt);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state    = ST_RUN;
                    st_d.swap     = cfg_swap;
                    st_d.addr     = cfg_base;
                    st_d.hdr_left = cfg_hdr_pairs;
                    st_d.acc      = {resume_hi, resume_lo} & keep_mask;
                    st_d.fill     = resume_cnt;
                    st_d.tot      = CNT_W'(resume_cnt);
                    st_d.hdr      = '0;
                    st_d.res      = '0;
                end
            end
            ST_RUN: begin
                if (accept) begin
                    st_d.acc  = mg_acc;
                    st_d.fill = mg_fill;
                    st_d.tot  = st_q.tot + CNT_W'(cw_len);
                    if (st_q.hdr_left != '0) begin
                        st_d.hdr      = st_q.hdr + CNT_W'(cw_len);
                        st_d.hdr_left = st_q.hdr_left - HDR_W'(1);
                    end else begin
                        st_d.res = st_q.res + CNT_W'(cw_len);
                    end
                    if (mg_full) begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_word = mg_word;
                        st_d.addr    = st_q.addr + ADDR_W'(1);
                    end
                    if (cw_last) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cw_ready = (st_q.state == ST_RUN);
    assign busy     = (st_q.state == ST_RUN);
    assign done     = st_q.done;
    assign wr_en    = st_q.wr_en;
    assign wr_addr  = st_q.wr_addr;
    assign pend_hi  = st_q.acc[WORD_W-1:HALF_W];
    assign pend_lo  = st_q.acc[HALF_W-1:0];
    assign pend_cnt = st_q.fill;
    assign tot_bits = st_q.tot;
    assign hdr_bits = st_q.hdr;
    assign res_bits = st_q.res;

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_ready) |-> (cw_len <= LEN_W'(WORD_W))); // R2
    AST_WRITE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> ($past(st_q.state) == ST_RUN)); // R3
    AST_PEND_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.acc << st_q.fill) == '0)); // R7
    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.hdr_left != '0) |=> $stable(st_q.res)); // R9
    AST_TOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.tot == $past(st_q.tot) + CNT_W'($past(cw_len)))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !busy); // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !cw_valid) |=> ($stable(st_q.addr) && $stable(st_q.tot) && $stable(st_q.swap))); // R12
endmodule

// File: tb/vlc_bit_packer_tb.sv
module vlc_bit_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_swap = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [9:0]  cfg_hdr_pairs = '0;
    logic [15:0] resume_hi = '0;
    logic [15:0] resume_lo = '0;
    logic [4:0]  resume_cnt = '0;
    logic        cw_valid = 1'b0;
    logic        cw_ready;
    logic [31:0] cw_code = '0;
    logic [5:0]  cw_len = '0;
    logic        cw_last = 1'b0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        busy, done;
    logic [15:0] pend_hi, pend_lo;
    logic [4:0]  pend_cnt;
    logic [23:0] tot_bits, hdr_bits, res_bits;

    always #10 clk = ~clk;

    vlc_bit_packer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_swap(cfg_swap), .cfg_base(cfg_base),
        .cfg_hdr_pairs(cfg_hdr_pairs), .resume_hi(resume_hi), .resume_lo(resume_lo),
        .resume_cnt(resume_cnt), .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_code(cw_code),
        .cw_len(cw_len), .cw_last(cw_last), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .pend_hi(pend_hi), .pend_lo(pend_lo), .pend_cnt(pend_cnt),
        .tot_bits(tot_bits), .hdr_bits(hdr_bits), .res_bits(res_bits)
    );

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_word;
    int          m_n;
    logic [31:0] exp_words[$];
    int          exp_addr;
    int          run_base;
    bit          m_swap;
    longint      m_tot, m_hdr, m_res;
    int          m_hdr_left;
    logic [31:0] first_wr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] place(input logic [31:0] w, input bit sw);
        if (sw) return {w[7:0], w[15:8], w[23:16], w[31:24]};
        return {w[15:8], w[7:0], w[31:24], w[23:16]};
    endfunction

    task automatic model_bit(input bit b);
        m_word[31-m_n] = b;
        m_n++;
        if (m_n == 32) begin
            exp_words.push_back(m_word);
            m_word = '0;
            m_n = 0;
        end
    endtask

    task automatic model_cw(input logic [31:0] code, input int len);
        for (int i = len - 1; i >= 0; i--) model_bit(code[i]);
        m_tot += len;
        if (m_hdr_left > 0) begin
            m_hdr += len;
            m_hdr_left--;
        end else begin
            m_res += len;
        end
    endtask

    // write monitor: R3 R4 R5 R6
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_words.size() == 0) begin
                chk(0, "R3", "unexpected write", wr_data, 0);
            end else begin
                logic [31:0] w;
                w = exp_words.pop_front();
                if (exp_addr == run_base) first_wr = wr_data;
                chk(wr_data == place(w, m_swap), m_swap ? "R5" : "R4", "write data",
                    wr_data, place(w, m_swap));
                chk(wr_addr == 16'(exp_addr), "R6", "write address", wr_addr, 16'(exp_addr));
                exp_addr++;
            end
        end
    end

    // mode 0 directed, 1 random full-width, 2 short; poke injects a start mid-run
    task automatic run_stream(input int base, input bit sw, input int pairs,
                              input logic [31:0] carry, input int cnt, input int n_cw,
                              input int mode, input bit poke);
        logic [31:0] dl_code[6];
        int          dl_len[6];
        logic [31:0] junk;
        dl_code = '{32'hA5A5_0F0F, 32'hFFFF_FFFF, 32'hFFFF_FFF3, 32'h0000_0001,
                    32'h0ABC_DEF1, 32'hFFFF_1234};
        dl_len  = '{32, 0, 5, 1, 27, 13};
        junk = $urandom();
        @(negedge clk);
        start = 1'b1;
        cfg_swap = sw;
        cfg_base = 16'(base);
        cfg_hdr_pairs = 10'(pairs);
        // bits after the count carry garbage that must be dropped (R8)
        resume_hi = 16'((carry | (junk & ~(32'hFFFF_FFFF << (32 - cnt)) & ((cnt == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFF))) >> 16);
        resume_lo = 16'(carry | (cnt == 0 ? junk : (junk & (32'hFFFF_FFFF >> cnt))));
        resume_cnt = 5'(cnt);
        m_word = '0;
        m_n = 0;
        for (int i = 0; i < cnt; i++) model_bit(carry[31-i]);
        m_tot = cnt;
        m_hdr = 0;
        m_res = 0;
        m_hdr_left = pairs;
        exp_addr = base;
        run_base = base;
        m_swap = sw;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && cw_ready == 1'b1, "R12", "ready during run", cw_ready, 1);
        chk(pend_cnt == 5'(cnt), "R8", "carry count loaded", pend_cnt, cnt);
        chk({pend_hi, pend_lo} == m_word, "R8", "carry bits masked", {pend_hi, pend_lo}, m_word);
        for (int i = 0; i < n_cw; i++) begin
            logic [31:0] c;
            int          l;
            if (poke && i == n_cw / 2) begin
                cw_valid = 1'b0;
                start = 1'b1;
                cfg_base = 16'hDEAD;
                cfg_swap = ~sw;
                resume_cnt = 5'd7;
                @(negedge clk);
                start = 1'b0;
                chk(busy == 1'b1 && tot_bits == 24'(m_tot), "R12", "start ignored in run",
                    tot_bits, m_tot);
            end
            if (mode == 0) begin
                c = dl_code[i % 6];
                l = dl_len[i % 6];
            end else if (mode == 1) begin
                c = $urandom();
                l = $urandom_range(0, 32);
            end else begin
                c = $urandom();
                l = $urandom_range(1, 8);
            end
            cw_valid = 1'b1;
            cw_code = c;
            cw_len = 6'(l);
            cw_last = (i == n_cw - 1);
            model_cw(c, l);
            @(negedge clk);
        end
        cw_valid = 1'b0;
        cw_last = 1'b0;
        #2;
        chk(done == 1'b1 && busy == 1'b0, "R11", "done after last", {done, busy}, 2'b10);
        chk(exp_words.size() == 0, "R3", "all full words written", exp_words.size(), 0);
        chk(pend_cnt == 5'(m_n), "R7", "pending count", pend_cnt, m_n);
        chk(pend_hi == m_word[31:16], "R7", "pending upper half", pend_hi, m_word[31:16]);
        chk(pend_lo == m_word[15:0], "R7", "pending lower half", pend_lo, m_word[15:0]);
        chk(tot_bits == 24'(m_tot), "R10", "total bits", tot_bits, m_tot);
        chk(hdr_bits == 24'(m_hdr), "R9", "header bits", hdr_bits, m_hdr);
        chk(res_bits == 24'(m_res), "R9", "residual bits", res_bits, m_res);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done lasts one cycle", done, 0);
        chk(wr_en == 1'b0 && cw_ready == 1'b0, "R12", "idle after run", cw_ready, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && wr_en == 0 && cw_ready == 0, "R1", "reset control",
            {busy, done, wr_en, cw_ready}, 0);
        chk(pend_hi == 0 && pend_lo == 0 && pend_cnt == 0, "R1", "reset pending",
            {pend_hi, pend_lo, pend_cnt}, 0);
        chk(tot_bits == 0 && hdr_bits == 0 && res_bits == 0, "R1", "reset counters",
            tot_bits | hdr_bits | res_bits, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R4: directed list, zero length and garbage above the length
        run_stream(16'h0100, 1'b0, 3, 32'h0, 0, 6, 0, 1'b0);
        chk(first_wr == 32'h0F0F_A5A5, "R4", "literal halfword layout", first_wr, 32'h0F0F_A5A5);
        // R8: resume the model's own pending bits, swap layout, all residual
        run_stream(16'h0200, 1'b1, 0, m_word, m_n, 300, 1, 1'b0);
        // R5 R9 R12 R13: literal swapped word, every codeword header, mid-run start
        @(negedge clk);
        start = 1'b1; cfg_swap = 1'b1; cfg_base = 16'h0300; cfg_hdr_pairs = 10'd1023;
        resume_cnt = 5'd0; resume_hi = 16'h0; resume_lo = 16'h0;
        m_word = '0; m_n = 0; m_tot = 0; m_hdr = 0; m_res = 0; m_hdr_left = 1023;
        exp_addr = 16'h0300; run_base = 16'h0300; m_swap = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cw_valid = 1'b1; cw_code = 32'h0123_4567; cw_len = 6'd32; cw_last = 1'b0;
        model_cw(32'h0123_4567, 32);
        @(negedge clk);
        cw_valid = 1'b0;
        #2;
        chk(wr_en == 1'b1 && wr_data == 32'h6745_2301, "R5", "literal byte-reversed layout",
            wr_data, 32'h6745_2301);
        @(negedge clk);
        start = 1'b1; cfg_base = 16'h0BAD; cfg_swap = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] c;
            int          l;
            c = $urandom();
            l = $urandom_range(1, 8);
            cw_valid = 1'b1; cw_code = c; cw_len = 6'(l); cw_last = (i == 39);
            model_cw(c, l);
            @(negedge clk);
        end
        cw_valid = 1'b0; cw_last = 1'b0;
        #2;
        chk(done == 1'b1, "R11", "done after header run", done, 1);
        chk(hdr_bits == 24'(m_hdr) && res_bits == 0, "R9", "all header at 1023 pairs",
            hdr_bits, m_hdr);
        chk(exp_addr == 16'h0305 || exp_words.size() == 0, "R13", "base kept after restart attempt",
            exp_addr, 16'h0305);
        @(negedge clk);
        // R8 R7: carry count 31 with garbage below it
        run_stream(16'h0400, 1'b0, 5, 32'hFFFF_FFFE, 31, 400, 1, 1'b1);
        // R9: two header pairs then residual, continuing the stream
        run_stream(16'h0500, 1'b1, 2, m_word, m_n, 50, 2, 1'b1);
        run_stream(16'hFFFE, 1'b0, 0, m_word, m_n, 120, 1, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "R11", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule